// File: doc/BRIEF.md
# Block Interrupt Summary Register

This block is the per-channel top level of an interrupt tree. A processor reads one 8-bit read-only byte to learn which functional block of the channel needs service. The byte holds two kinds of bit. Summary bits mirror a pending request held for a lower-level block, and they clear only when that block's own status register is read. Sticky event bits record that an event took place, and they clear when the summary byte itself is read.

The block watches the channel's shared read bus, which carries an address and a read strobe. From that bus it decodes reads of the summary byte and of each source status register. It takes event pulses from a loopback-code detector, from six HDLC data-link status sources, from a recovered-clock-loss detector, and from a one-second timer. It also takes an enable for clock-loss detection and a per-bit interrupt enable. It drives one combined interrupt line.

Top module: `blk_irq_summary`

## Requirements
- R1: After reset all status bits are 0 and `irq_o` is 0.
- R2: `rd_data_o` shows the status byte in the same cycle that `rd_en_i` is high with `rd_addr_i` = 0x00. In every other cycle it reads 0x00, including reads of the source registers.
- R3: Bit 7 and bits 2:0 of the status byte always read 0.
- R4: Bit 6 sets on the edge after an `lbc_evt_i` pulse. It survives reads of the summary byte. It clears on the edge that ends a read at address 0x0A.
- R5: While `clk_loss_det_en_i` is 1, bit 5 sets on the edge after a `clk_loss_evt_i` pulse. It stays set until the edge that ends a summary read.
- R6: While `clk_loss_det_en_i` is 0, a `clk_loss_evt_i` pulse leaves bit 5 unchanged.
- R7: Bit 4 sets on the edge after a `one_sec_evt_i` pulse. It stays set until the edge that ends a summary read.
- R8: Bit 3 is the OR of six pending flags. A pulse on `hdlc_evt_i[k]` sets flag k. Each flag has its own clearing address: flag 0 at 0x06, flag 1 at 0x16, flag 2 at 0x26, flag 3 at 0x10, flag 4 at 0x18 and flag 5 at 0x28. A read at that address clears only that flag, so bit 3 falls only after every set flag has been read.
- R9: An event pulse in the same cycle as a summary read is not lost. The read returns the old value and the flag is set afterwards.
- R10: `irq_o` is the OR of status bits 6 to 3, where status bit b is gated by `irq_en_i[b-3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Read strobe of the channel register bus |
| rd_addr_i | input | 8 | Block-relative read address |
| rd_data_o | output | 8 | Status byte during a summary read, else 0 |
| lbc_evt_i | input | 1 | Loopback-code block raises a request |
| hdlc_evt_i | input | 6 | Per-source data-link request pulses |
| clk_loss_evt_i | input | 1 | Recovered-clock-loss event pulse |
| clk_loss_det_en_i | input | 1 | Clock-loss detection enable |
| one_sec_evt_i | input | 1 | One-second tick pulse |
| irq_en_i | input | 4 | Enables for status bits 6..3 (index = bit-3) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench reads the summary byte twice after raising the loopback-code and HDLC requests. A design that wrongly cleared summary bits on a summary read would drop bits 6 or 3 on the second read. It then services the HDLC sources one at a time, in an order that differs from the order they were raised. Bit 3 falling early would show that the design cleared the whole group on one source read, or clear on the wrong address. The bench pulses clock-loss with detection disabled, to catch a missing enable gate. It also lands a one-second tick on the same edge as a summary read. A design that lets the clear win would lose that tick.

// File: rtl/irq_sum_pkg.sv
package irq_sum_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int N_HDLC = 6;
  localparam int N_IRQ  = 4;

  localparam int BIT_LBC  = 6;
  localparam int BIT_CLK  = 5;
  localparam int BIT_SEC  = 4;
  localparam int BIT_HDLC = 3;

  localparam logic [ADDR_W-1:0] SUM_OFS = 8'h00;
  localparam logic [ADDR_W-1:0] LBC_OFS = 8'h0A;

  // clearing address of each data-link source register
  function automatic logic [ADDR_W-1:0] hdlc_ofs(input int k);
    case (k)
      0:       return 8'h06;
      1:       return 8'h16;
      2:       return 8'h26;
      3:       return 8'h10;
      4:       return 8'h18;
      default: return 8'h28;
    endcase
  endfunction
endpackage

// File: rtl/irq_flag.sv
module irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set wins over clear so a coincident event survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/irq_hdlc_bank.sv
module irq_hdlc_bank
  import irq_sum_pkg::*;
#(
  parameter int N = N_HDLC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [N-1:0]      evt_i,
  output logic              pend_o
);
  logic [N-1:0] flag_q;

  for (genvar k = 0; k < N; k++) begin : g_src
    logic src_rd;
    assign src_rd = rd_en_i && (rd_addr_i == hdlc_ofs(k));
    irq_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt_i[k]),
      .clr_i  (src_rd),
      .q_o    (flag_q[k])
    );
  end

  assign pend_o = |flag_q;
endmodule

// File: rtl/blk_irq_summary.sv
module blk_irq_summary
  import irq_sum_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              lbc_evt_i,
  input  logic [N_HDLC-1:0] hdlc_evt_i,
  input  logic              clk_loss_evt_i,
  input  logic              clk_loss_det_en_i,
  input  logic              one_sec_evt_i,
  input  logic [N_IRQ-1:0]  irq_en_i,
  output logic              irq_o
);
  logic sum_rd, lbc_rd;
  logic lbc_q, clk_q, sec_q, hdlc_q;
  logic [DATA_W-1:0] status;

  assign sum_rd = rd_en_i && (rd_addr_i == SUM_OFS);
  assign lbc_rd = rd_en_i && (rd_addr_i == LBC_OFS);

  irq_flag u_lbc (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(lbc_evt_i), .clr_i(lbc_rd), .q_o(lbc_q)
  );

  irq_flag u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(clk_loss_evt_i && clk_loss_det_en_i), .clr_i(sum_rd), .q_o(clk_q)
  );

  irq_flag u_sec (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(one_sec_evt_i), .clr_i(sum_rd), .q_o(sec_q)
  );

  irq_hdlc_bank #(.N(N_HDLC)) u_hdlc (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .evt_i(hdlc_evt_i), .pend_o(hdlc_q)
  );

  always_comb begin
    status           = '0;
    status[BIT_LBC]  = lbc_q;
    status[BIT_CLK]  = clk_q;
    status[BIT_SEC]  = sec_q;
    status[BIT_HDLC] = hdlc_q;
  end

  assign rd_data_o = sum_rd ? status : '0;
  assign irq_o     = |(status[BIT_LBC:BIT_HDLC] & irq_en_i);
endmodule

// File: rtl/irq_summary_chk.sv
module irq_summary_chk
  import irq_sum_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              clk_loss_evt_i,
  input logic              clk_loss_det_en_i,
  input logic              one_sec_evt_i,
  input logic [N_IRQ-1:0]  irq_en_i,
  input logic              irq_o,
  input logic [DATA_W-1:0] status
);
  logic is_sum_rd, is_lbc_rd;
  assign is_sum_rd = rd_en_i && (rd_addr_i == SUM_OFS);
  assign is_lbc_rd = rd_en_i && (rd_addr_i == LBC_OFS);

  assert_reserved_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[7] == 1'b0) && (rd_data_o[2:0] == 3'b000));

  assert_lbc_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status[BIT_LBC] && !is_lbc_rd) |=> status[BIT_LBC]);

  assert_clk_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_loss_evt_i && clk_loss_det_en_i) |=> status[BIT_CLK]);

  assert_clk_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status[BIT_CLK] && !(clk_loss_evt_i && clk_loss_det_en_i)) |=> !status[BIT_CLK]);

  assert_sec_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_sum_rd && !one_sec_evt_i) |=> !status[BIT_SEC]);

  assert_hdlc_survives_sum_rd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_sum_rd && status[BIT_HDLC]) |=> status[BIT_HDLC]);

  assert_event_not_lost_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_sum_rd && one_sec_evt_i) |=> status[BIT_SEC]);

  assert_irq_gating_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(status[BIT_LBC:BIT_HDLC] & irq_en_i));
endmodule

bind blk_irq_summary irq_summary_chk u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .rd_en_i           (rd_en_i),
  .rd_addr_i         (rd_addr_i),
  .rd_data_o         (rd_data_o),
  .clk_loss_evt_i    (clk_loss_evt_i),
  .clk_loss_det_en_i (clk_loss_det_en_i),
  .one_sec_evt_i     (one_sec_evt_i),
  .irq_en_i          (irq_en_i),
  .irq_o             (irq_o),
  .status            (status)
);

// File: tb/tb_blk_irq_summary.sv
module tb_blk_irq_summary;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [7:0] rd_addr_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       lbc_evt_i = 1'b0;
  logic [5:0] hdlc_evt_i = 6'h00;
  logic       clk_loss_evt_i = 1'b0;
  logic       clk_loss_det_en_i = 1'b1;
  logic       one_sec_evt_i = 1'b0;
  logic [3:0] irq_en_i = 4'h0;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  blk_irq_summary dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .lbc_evt_i(lbc_evt_i), .hdlc_evt_i(hdlc_evt_i),
    .clk_loss_evt_i(clk_loss_evt_i), .clk_loss_det_en_i(clk_loss_det_en_i),
    .one_sec_evt_i(one_sec_evt_i), .irq_en_i(irq_en_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] addr, output logic [7:0] data);
    @(negedge clk_i);
    rd_en_i = 1'b1; rd_addr_i = addr;
    #1 data = rd_data_o;
    @(negedge clk_i);
    rd_en_i = 1'b0; rd_addr_i = 8'h00;
  endtask

  task automatic pulse(input logic lbc, input logic [5:0] h, input logic cl, input logic sec);
    @(negedge clk_i);
    lbc_evt_i = lbc; hdlc_evt_i = h; clk_loss_evt_i = cl; one_sec_evt_i = sec;
    @(negedge clk_i);
    lbc_evt_i = 1'b0; hdlc_evt_i = 6'h00; clk_loss_evt_i = 1'b0; one_sec_evt_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(8'h00, d);
    chk("R1 status after reset", d, 8'h00);
    chk("R1 irq after reset", {7'h0, irq_o}, 8'h00);
  endtask

  task automatic t_sticky();
    logic [7:0] d;
    clk_loss_det_en_i = 1'b1;
    pulse(1'b0, 6'h00, 1'b1, 1'b1);
    rd(8'h05, d);
    chk("R2 non-summary address reads zero", d, 8'h00);
    rd(8'h00, d);
    chk("R5 R7 sticky bits set", d, 8'h30);
    rd(8'h00, d);
    chk("R5 R7 sticky bits cleared by summary read", d, 8'h00);
  endtask

  task automatic t_summary();
    logic [7:0] d;
    pulse(1'b1, 6'b000100, 1'b0, 1'b0);
    rd(8'h00, d);
    chk("R4 R8 summary bits set", d, 8'h48);
    rd(8'h00, d);
    chk("R4 R8 summary bits survive summary read", d, 8'h48);
    rd(8'h0A, d);
    chk("R2 source register read gives zero here", d, 8'h00);
    rd(8'h00, d);
    chk("R4 lbc cleared by 0x0A read", d, 8'h08);
    pulse(1'b0, 6'b100001, 1'b0, 1'b0);
    rd(8'h26, d);
    rd(8'h00, d);
    chk("R8 bit3 held after flag2 serviced", d, 8'h08);
    rd(8'h06, d);
    rd(8'h10, d);
    rd(8'h00, d);
    chk("R8 bit3 held, flag5 still pending", d, 8'h08);
    rd(8'h28, d);
    rd(8'h00, d);
    chk("R8 bit3 cleared after last source", d, 8'h00);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    clk_loss_det_en_i = 1'b0;
    pulse(1'b0, 6'h00, 1'b1, 1'b0);
    rd(8'h00, d);
    chk("R6 clock loss ignored when disabled", d, 8'h00);
    clk_loss_det_en_i = 1'b1;
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    @(negedge clk_i);
    rd_en_i = 1'b1; rd_addr_i = 8'h00; one_sec_evt_i = 1'b1;
    #1 chk("R9 coincident read returns old value", rd_data_o, 8'h00);
    @(negedge clk_i);
    rd_en_i = 1'b0; one_sec_evt_i = 1'b0;
    rd(8'h00, d);
    chk("R9 coincident event kept", d, 8'h10);
    rd(8'h00, d);
    chk("R9 cleared afterwards", d, 8'h00);
  endtask

  task automatic t_all_and_irq();
    logic [7:0] d;
    irq_en_i = 4'h0;
    pulse(1'b1, 6'b111111, 1'b1, 1'b1);
    #1 chk("R10 irq masked", {7'h0, irq_o}, 8'h00);
    irq_en_i = 4'b1000;
    #1 chk("R10 irq from bit6", {7'h0, irq_o}, 8'h01);
    rd(8'h00, d);
    chk("R3 reserved bits zero with all set", d & 8'h87, 8'h00);
    chk("R3 full byte", d, 8'h78);
    rd(8'h0A, d);
    #1 chk("R10 irq drops with bit6", {7'h0, irq_o}, 8'h00);
    irq_en_i = 4'b0001;
    #1 chk("R10 irq from bit3", {7'h0, irq_o}, 8'h01);
    for (int k = 0; k < 6; k++) begin
      logic [7:0] a;
      case (k)
        0: a = 8'h06; 1: a = 8'h16; 2: a = 8'h26;
        3: a = 8'h10; 4: a = 8'h18; default: a = 8'h28;
      endcase
      rd(a, d);
    end
    rd(8'h00, d);
    chk("R8 all sources serviced", d, 8'h00);
    #1 chk("R10 irq idle", {7'h0, irq_o}, 8'h00);
    irq_en_i = 4'h0;
  endtask

  initial begin
    #10000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_sticky();
    t_summary();
    t_disabled();
    t_same_cycle();
    t_all_and_irq();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule